// File: doc/BRIEF.md
# Interleaved Per-Channel Offset Canceller

This block sits right behind a time-interleaved converter array. It takes the merged sample stream, in which consecutive samples come from successive sub-converters, and removes the DC offset that each sub-converter adds. A rotating channel pointer assigns every accepted sample to a lane. Each lane keeps its own running sum over a fixed block of its own samples. At the end of every block the lane's offset estimate becomes the block mean, and the accumulation starts again.

Every sample leaves one cycle later in its original order, minus the current estimate of its lane, saturated to the data width. The estimates are refreshed continuously with no break in the stream. Later stages that correlate the stream for gain or skew errors therefore see data with zero mean per lane. The method only assumes that the analog input has zero mean.

Top module: `tiadc_offset_cancel`

## Requirements
- R1: After reset `out_valid` is 0, `out_data` is 0, the channel pointer points to lane 0 and every lane estimate is 0.
- R2: The k-th accepted sample after reset (counting from 0) belongs to lane k mod NUM_CH, reported on `out_chan`. Cycles with `in_valid` low do not advance the pointer.
- R3: `out_valid` equals `in_valid` of the previous cycle.
- R4: For an accepted sample d of lane i, `out_data` one cycle later is d minus the estimate of lane i held when d arrived.
- R5: When a lane has taken 2^AVG_LOG2 samples since its last update, its estimate becomes floor(sum/2^AVG_LOG2), rounded toward minus infinity. The sample that completes the block is still corrected with the old estimate. The estimate changes at no other time.
- R6: A sample changes the accumulator and estimate of its own lane only.
- R7: The difference is clamped to the range -2^(DATA_W-1) to 2^(DATA_W-1)-1 (-32768 and 32767 by default).
- R8: After an update the lane's sum restarts from zero, so the next estimate depends only on the samples of the next block.
- R9: While `out_valid` is 0, `out_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_data | input | DATA_W | Signed interleaved sample |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | DATA_W | Signed corrected sample |
| out_chan | output | log2(NUM_CH) | Lane of the corrected sample |

## Verification
On every cycle the assertions check the pointer rotation and stall behaviour, the one-cycle valid latency, the lane tag of each output, that at most one lane takes a sample, and that an estimate moves only on its block-end cycle. The bench has to show the numerical content. This covers the exact correction value and the floor rounding of negative means. It also covers saturation at both limits, that a block's estimate does not depend on earlier blocks, and that lanes stay separate. These are shown with directed per-lane offsets and a seeded random stream with random bubbles.

// File: rtl/tiadc_oc_pkg.sv
package tiadc_oc_pkg;
  localparam int unsigned OC_DATA_W   = 16;
  localparam int unsigned OC_NUM_CH   = 4;
  localparam int unsigned OC_AVG_LOG2 = 6;

  // pointer width, at least one bit
  function automatic int unsigned oc_idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tiadc_oc_chan_sel.sv
module tiadc_oc_chan_sel #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_i,
  output logic [CH_W-1:0] ptr_o,
  output logic [NUM_CH-1:0] take_o
);
  localparam logic [CH_W-1:0] LAST = CH_W'(NUM_CH - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_o <= '0;
    end else if (adv_i) begin
      ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_take
    assign take_o[g] = adv_i && (ptr_o == CH_W'(g));
  end
endmodule

// File: rtl/tiadc_oc_lane_est.sv
module tiadc_oc_lane_est #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned AVG_LOG2 = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take_i,
  input  logic signed [DATA_W-1:0] data_i,
  output logic signed [DATA_W-1:0] est_o,
  output logic                     blk_done_o
);
  localparam int unsigned ACC_W = DATA_W + AVG_LOG2;

  logic signed [ACC_W-1:0] acc_q;
  logic [AVG_LOG2-1:0]     cnt_q;
  logic signed [ACC_W-1:0] sum_next;

  // mean of a full block: arithmetic shift gives floor rounding
  function automatic logic signed [DATA_W-1:0] block_mean(input logic signed [ACC_W-1:0] s);
    logic signed [ACC_W-1:0] sh;
    sh = s >>> AVG_LOG2;
    return sh[DATA_W-1:0];
  endfunction

  assign sum_next   = acc_q + ACC_W'(data_i);
  assign blk_done_o = take_i && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
      est_o <= '0;
    end else if (take_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (blk_done_o) begin
        est_o <= block_mean(sum_next);
        acc_q <= '0;
      end else begin
        acc_q <= sum_next;
      end
    end
  end
endmodule

// File: rtl/tiadc_offset_cancel.sv
module tiadc_offset_cancel
  import tiadc_oc_pkg::*;
#(
  parameter int unsigned DATA_W   = OC_DATA_W,
  parameter int unsigned NUM_CH   = OC_NUM_CH,
  parameter int unsigned AVG_LOG2 = OC_AVG_LOG2,
  localparam int unsigned CH_W    = oc_idx_w(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data,
  output logic [CH_W-1:0]          out_chan
);
  logic [CH_W-1:0]          chan_ptr;
  logic [NUM_CH-1:0]        take;
  logic [NUM_CH-1:0]        blk_done;
  logic [NUM_CH*DATA_W-1:0] est_flat;
  logic signed [DATA_W-1:0] est_sel;

  // clamp a - b into the signed data range
  function automatic logic signed [DATA_W-1:0] sat_sub(
    input logic signed [DATA_W-1:0] a,
    input logic signed [DATA_W-1:0] b
  );
    logic signed [DATA_W:0] d;
    d = {a[DATA_W-1], a} - {b[DATA_W-1], b};
    if (d[DATA_W] != d[DATA_W-1])
      return d[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    return d[DATA_W-1:0];
  endfunction

  tiadc_oc_chan_sel #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (in_valid),
    .ptr_o  (chan_ptr),
    .take_o (take)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    tiadc_oc_lane_est #(.DATA_W(DATA_W), .AVG_LOG2(AVG_LOG2)) u_est (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take[g]),
      .data_i     (in_data),
      .est_o      (est_flat[g*DATA_W +: DATA_W]),
      .blk_done_o (blk_done[g])
    );
  end

  always_comb begin
    est_sel = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan_ptr == CH_W'(i)) est_sel = est_flat[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_chan  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= sat_sub(in_data, est_sel);
        out_chan <= chan_ptr;
      end
    end
  end
endmodule

// File: rtl/tiadc_oc_chk.sv
module tiadc_oc_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic [CH_W-1:0]          out_chan,
  input logic [CH_W-1:0]          chan_ptr,
  input logic [NUM_CH-1:0]        take,
  input logic [NUM_CH-1:0]        blk_done,
  input logic [NUM_CH*DATA_W-1:0] est_flat
);
  a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> chan_ptr == CH_W'((32'($past(chan_ptr)) + 1) % NUM_CH));

  a_r2_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(chan_ptr));

  a_r3_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r3_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r4_chan_tag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_chan == $past(chan_ptr));

  a_r6_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane_chk
    a_r5_est_still: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_done[g] |=> $stable(est_flat[g*DATA_W +: DATA_W]));
  end
endmodule

bind tiadc_offset_cancel tiadc_oc_chk #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_chan  (out_chan),
  .chan_ptr  (chan_ptr),
  .take      (take),
  .blk_done  (blk_done),
  .est_flat  (est_flat)
);

// File: tb/tiadc_offset_cancel_tb.sv
`timescale 1ns/1ps
module tiadc_offset_cancel_tb;
  localparam int NCH = 4;
  localparam int BLK = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [15:0] out_data;
  logic [1:0] out_chan;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  longint m_acc[NCH];
  int m_cnt[NCH];
  longint m_est[NCH];
  int m_ptr;
  longint m_last;

  always #2.5 clk = ~clk;

  tiadc_offset_cancel u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan)
  );

  function automatic longint clamp16(input longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic longint floor_div(input longint s, input longint n);
    longint q;
    q = s / n;
    if (s < 0 && (s % n) != 0) q = q - 1;
    return q;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_acc[i] = 0; m_cnt[i] = 0; m_est[i] = 0;
    end
    m_ptr = 0; m_last = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    @(negedge clk); @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(out_data == 0, "R1", out_data, 0);
    model_reset();
    rst_n = 1'b1;
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic step(input bit v, input int d, input string tag);
    longint raw, exp;
    int ch;
    string t;
    in_valid = v;
    in_data = 16'(d);
    ch = m_ptr;
    raw = longint'(d) - m_est[ch];
    exp = clamp16(raw);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == v, "R3", out_valid, v);
    if (v) begin
      t = (raw != exp) ? "R7" : tag;
      check(out_chan == 2'(ch), "R2", out_chan, ch);
      check(longint'(out_data) == exp, t, out_data, exp);
      m_acc[ch] += d;
      m_cnt[ch]++;
      if (m_cnt[ch] == BLK) begin
        m_est[ch] = floor_div(m_acc[ch], BLK);
        m_acc[ch] = 0;
        m_cnt[ch] = 0;
      end
      m_ptr = (m_ptr + 1) % NCH;
      m_last = exp;
    end else begin
      check(longint'(out_data) == m_last, "R9", out_data, m_last);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int offs[NCH];
    int r;
    offs = '{300, -200, 50, -7};
    void'($urandom(32'd715));
    model_reset();
    do_reset();

    // R4/R6: distinct constant offset per lane, with a few bubbles
    for (int k = 0; k < NCH * BLK * 2; k++) begin
      if (k % 37 == 5) step(1'b0, 0, "R9");
      step(1'b1, offs[k % NCH], (k < NCH * BLK) ? "R4" : "R6");
    end

    // R5: negative block sum not a multiple of the block, floor rounding
    for (int k = 0; k < NCH * BLK; k++)
      step(1'b1, (k == 0) ? -33 : ((k % NCH == 1) ? 5 : 0), "R5");
    for (int k = 0; k < NCH * 2; k++) step(1'b1, 0, "R5");

    // R8: second block uses only its own samples
    for (int k = 0; k < NCH * BLK * 2; k++)
      step(1'b1, (k < NCH * BLK) ? 1000 : -20, "R8");

    // R7: saturation at both limits after fresh reset
    do_reset();
    for (int k = 0; k < NCH * BLK; k++)
      step(1'b1, (k % NCH == 0) ? 1000 : ((k % NCH == 1) ? -1000 : 0), "R4");
    step(1'b1, -32768, "R7");
    step(1'b1, 32767, "R7");
    step(1'b1, 32767, "R7");
    step(1'b1, -32768, "R7");

    // R4: random offsets with noise and random bubbles
    for (int k = 0; k < 6000; k++) begin
      r = $urandom_range(9, 0);
      if (r == 0) step(1'b0, 0, "R9");
      else step(1'b1, offs[m_ptr] * 40 + $signed($urandom_range(8000, 0)) - 4000, "R4");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule